// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzler

This block rewrites linear byte addresses for clients of tiled surfaces, so that the memory channel they select matches the channel chosen by an interleaving memory controller. Channels alternate every 64 bytes, so address bit 6 picks the channel. For tiled surfaces the controller also folds a selection of higher address bits into that choice. The block XORs output bit 6 with the higher bits that the active swizzle mode selects. Every other address bit passes through unchanged.

Two 3-bit mode registers hold the swizzle mode, one for X-tiled surfaces and one for Y-tiled surfaces. They are written through a small configuration port. Each address beat arrives on a valid/ready stream together with a 2-bit tiling code. It leaves one cycle later on a registered valid/ready stream. The output beat carries the rewritten address, the tiling that was actually applied, the physical swizzle mode, and a reported mode in which any bit-17 component has been removed.

A mode that cannot be determined makes the beat untiled. Such a beat gets no swizzle and keeps its address unchanged. Detecting the mode from the memory configuration is left to software. No data is moved by this block.

Top module: `tile_addr_swizzle`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and both mode registers hold mode 0 (none).
- R2: A beat with tiling code 0 (linear) leaves with its address unchanged, out_tiling 0, out_mode 0 and out_phys_mode 0.
- R3: Tiling code 1 (X) uses the mode register written with cfg_sel=0. Tiling code 2 (Y) uses the register written with cfg_sel=1.
- R4: Mode encodings are 0 none, 1 bit 9, 2 bits 9+10, 3 bits 9+11, 4 bits 9+10+11, 5 bits 9+17, 6 bits 9+10+17 and 7 unknown. Output bit 6 equals input bit 6 XOR every address bit the applied mode lists.
- R5: All output address bits other than bit 6 equal the corresponding input bits.
- R6: With mode 7 in the selected register, the beat leaves with out_tiling 0, out_mode 0, out_phys_mode 0 and its address unchanged.
- R7: out_phys_mode carries the applied mode (0..6). out_mode reports it with bit 17 removed: 5 is reported as 1, 6 as 2, and every other mode unchanged.
- R8: A beat accepted at a clock edge (in_valid and in_ready both high) appears on the output valid right after that edge.
- R9: While out_valid is high and out_ready is low, in_ready is low and all output fields hold their values.
- R10: A mode write affects only beats accepted at a later edge than the write. A beat already accepted, including one stalled on the output, keeps the mode that was captured with it.
- R11: Tiling code 3 is treated as linear, exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_sel | input | 1 | 0 selects the X mode register, 1 the Y mode register |
| cfg_mode | input | 3 | Mode value to write |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_addr | input | AW | Linear byte address |
| in_tiling | input | 2 | 0 linear, 1 X, 2 Y, 3 treated as linear |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_addr | output | AW | Swizzled address |
| out_tiling | output | 2 | Tiling actually applied |
| out_mode | output | 3 | Reported swizzle mode, bit 17 removed |
| out_phys_mode | output | 3 | Physical swizzle mode applied to the address |

## Verification
The bound checker evaluates properties on every cycle:
- the one-cycle appearance of accepted beats;
- output stability and in_ready low during a stall;
- pass-through of every bit except bit 6;
- the rule that a reported mode never contains bit 17 and never shows an unknown mode;
- the zero modes attached to linear output beats.

Some behaviour can only be shown by the bench's scenarios. These are the exact XOR result for each of the eight modes under both X and Y tiling, the fallback to linear on an unknown mode, and the rule that a mode write during a stall does not disturb the held beat. The bench covers them with a scoreboard fed by its own model of the mode registers, under both free-flowing and randomly backpressured output.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int MODE_W = 3;
  localparam int TILE_W = 2;
  localparam int CHAN_BIT = 6;
  localparam int MIN_AW = 18;

  typedef enum logic [MODE_W-1:0] {
    SWZ_NONE     = 3'd0,
    SWZ_B9       = 3'd1,
    SWZ_B9_10    = 3'd2,
    SWZ_B9_11    = 3'd3,
    SWZ_B9_10_11 = 3'd4,
    SWZ_B9_17    = 3'd5,
    SWZ_B9_10_17 = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swz_mode_e;

  typedef enum logic [TILE_W-1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tile_e;

  // Channel flip term: XOR of the higher bits the mode folds into bit 6.
  function automatic logic chan_flip(input swz_mode_e m, input logic b9,
                                     input logic b10, input logic b11,
                                     input logic b17);
    logic use10, use11, use17, any;
    any   = (m != SWZ_NONE) && (m != SWZ_UNKNOWN);
    use10 = (m == SWZ_B9_10) || (m == SWZ_B9_10_11) || (m == SWZ_B9_10_17);
    use11 = (m == SWZ_B9_11) || (m == SWZ_B9_10_11);
    use17 = (m == SWZ_B9_17) || (m == SWZ_B9_10_17);
    return (any & b9) ^ (use10 & b10) ^ (use11 & b11) ^ (use17 & b17);
  endfunction

  // Reported mode hides the bit-17 component.
  function automatic swz_mode_e hide_b17(input swz_mode_e m);
    case (m)
      SWZ_B9_17:    return SWZ_B9;
      SWZ_B9_10_17: return SWZ_B9_10;
      default:      return m;
    endcase
  endfunction
endpackage

// File: rtl/swz_mode_regs.sv
module swz_mode_regs
  import swz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [MODE_W-1:0] cfg_mode,
  output swz_mode_e         x_mode,
  output swz_mode_e         y_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_mode <= SWZ_NONE;
      y_mode <= SWZ_NONE;
    end else if (cfg_we) begin
      if (cfg_sel) y_mode <= swz_mode_e'(cfg_mode);
      else         x_mode <= swz_mode_e'(cfg_mode);
    end
  end
endmodule

// File: rtl/swz_resolve.sv
module swz_resolve
  import swz_pkg::*;
(
  input  logic [TILE_W-1:0] tiling,
  input  swz_mode_e         x_mode,
  input  swz_mode_e         y_mode,
  output tile_e             eff_tiling,
  output swz_mode_e         phys_mode,
  output swz_mode_e         rep_mode
);
  swz_mode_e sel_mode;
  logic      tiled_req;

  always_comb begin
    tiled_req = 1'b1;
    sel_mode  = SWZ_NONE;
    case (tile_e'(tiling))
      TILE_X:  sel_mode = x_mode;
      TILE_Y:  sel_mode = y_mode;
      default: tiled_req = 1'b0;
    endcase
    if (!tiled_req || sel_mode == SWZ_UNKNOWN) begin
      eff_tiling = TILE_LINEAR;
      phys_mode  = SWZ_NONE;
    end else begin
      eff_tiling = tile_e'(tiling);
      phys_mode  = sel_mode;
    end
    rep_mode = hide_b17(phys_mode);
  end
endmodule

// File: rtl/swz_addr_xform.sv
module swz_addr_xform
  import swz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  swz_mode_e     mode,
  output logic [AW-1:0] addr_o
);
  logic flip;

  always_comb begin
    flip = chan_flip(mode, addr_i[9], addr_i[10], addr_i[11], addr_i[17]);
    addr_o = addr_i;
    addr_o[CHAN_BIT] = addr_i[CHAN_BIT] ^ flip;
  end
endmodule

// File: rtl/tile_addr_swizzle.sv
module tile_addr_swizzle
  import swz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [TILE_W-1:0] in_tiling,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic [TILE_W-1:0] out_tiling,
  output logic [MODE_W-1:0] out_mode,
  output logic [MODE_W-1:0] out_phys_mode
);
  localparam int AW_CHECK = (AW >= MIN_AW) ? 1 : 0;

  generate
    if (AW_CHECK == 0) begin : g_bad_aw
      initial $error("tile_addr_swizzle: AW must be at least %0d", MIN_AW);
    end
  endgenerate

  swz_mode_e     x_mode, y_mode;
  tile_e         eff_tiling;
  swz_mode_e     phys_mode, rep_mode;
  logic [AW-1:0] swz_addr;

  // Named internal events used by the checker.
  logic accept_ev;
  logic stall_ev;

  swz_mode_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_mode(cfg_mode), .x_mode(x_mode), .y_mode(y_mode)
  );

  swz_resolve u_resolve (
    .tiling(in_tiling), .x_mode(x_mode), .y_mode(y_mode),
    .eff_tiling(eff_tiling), .phys_mode(phys_mode), .rep_mode(rep_mode)
  );

  swz_addr_xform #(.AW(AW)) u_xform (
    .addr_i(in_addr), .mode(phys_mode), .addr_o(swz_addr)
  );

  assign in_ready  = !out_valid || out_ready;
  assign accept_ev = in_valid && in_ready;
  assign stall_ev  = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_addr      <= '0;
      out_tiling    <= TILE_LINEAR;
      out_mode      <= SWZ_NONE;
      out_phys_mode <= SWZ_NONE;
    end else begin
      if (accept_ev) begin
        out_addr      <= swz_addr;
        out_tiling    <= eff_tiling;
        out_mode      <= rep_mode;
        out_phys_mode <= phys_mode;
      end
      if (accept_ev)      out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tile_addr_swizzle_chk.sv
module tile_addr_swizzle_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [AW-1:0] in_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [1:0]    out_tiling,
  input logic [2:0]    out_mode,
  input logic [2:0]    out_phys_mode,
  input logic          accept_ev,
  input logic          stall_ev
);
  localparam logic [AW-1:0] KEEP = ~(AW'(1) << 6);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> out_valid);

  p_stall_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ev |=> (out_valid && $stable(out_addr) && $stable(out_tiling)
                  && $stable(out_mode) && $stable(out_phys_mode)));

  p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((out_addr & KEEP) == ($past(in_addr) & KEEP)));

  p_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode <= 3'd4 && out_phys_mode != 3'd7));

  p_downgrade_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phys_mode == 3'd5) |-> (out_mode == 3'd1));

  p_linear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tiling == 2'd0) |-> (out_mode == 3'd0 && out_phys_mode == 3'd0));
endmodule

bind tile_addr_swizzle tile_addr_swizzle_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_tiling(out_tiling), .out_mode(out_mode),
  .out_phys_mode(out_phys_mode), .accept_ev(accept_ev), .stall_ev(stall_ev)
);

// File: tb/test_tile_addr_swizzle.sv
module test_tile_addr_swizzle;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [2:0]    cfg_mode = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [1:0]    in_tiling = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic [1:0]    out_tiling;
  logic [2:0]    out_mode, out_phys_mode;

  int checks = 0;
  int errors = 0;
  logic [2:0] mdl_x = 3'd0, mdl_y = 3'd0;
  logic       bp_en = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;
  logic [31:0] bp_lfsr = 32'hACE1_0BAD;
  bit done = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    til;
    logic [2:0]    rep;
    logic [2:0]    phys;
    string         req;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_addr_swizzle #(.AW(AW)) i_tile_addr_swizzle (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_mode(cfg_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_tiling(in_tiling), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_tiling(out_tiling),
    .out_mode(out_mode), .out_phys_mode(out_phys_mode)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] bits_of(input logic [2:0] m);
    case (m)
      3'd1: return 32'h0000_0200;
      3'd2: return 32'h0000_0600;
      3'd3: return 32'h0000_0A00;
      3'd4: return 32'h0000_0E00;
      3'd5: return 32'h0002_0200;
      3'd6: return 32'h0002_0600;
      default: return '0;
    endcase
  endfunction

  function automatic exp_t model(input logic [AW-1:0] a, input logic [1:0] t);
    exp_t e;
    logic [2:0] m;
    m = (t == 2'd1) ? mdl_x : (t == 2'd2) ? mdl_y : 3'd7;
    if (t == 2'd0 || t == 2'd3) begin
      e.req = (t == 2'd3) ? "R11" : "R2";
      e.til = 2'd0; e.phys = 3'd0; e.rep = 3'd0; e.addr = a;
    end else if (m == 3'd7) begin
      e.req = "R6";
      e.til = 2'd0; e.phys = 3'd0; e.rep = 3'd0; e.addr = a;
    end else begin
      e.req = (m >= 3'd5) ? "R7" : (t == 2'd2) ? "R3" : "R4";
      e.til = t; e.phys = m;
      e.rep = (m == 3'd5) ? 3'd1 : (m == 3'd6) ? 3'd2 : m;
      e.addr = a ^ ({{(AW-1){1'b0}}, ^(a & bits_of(m))} << 6);
    end
    return e;
  endfunction

  task automatic write_mode(input logic sel, input logic [2:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_mode = m;
    @(posedge clk);
    if (sel) mdl_y = m; else mdl_x = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: pushes the expectation at the accepting edge.
  task automatic send(input logic [AW-1:0] a, input logic [1:0] t);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_tiling = t;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        sb.push_back(model(a, t));
        break;
      end
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  // Random backpressure.
  always @(negedge clk) begin
    bp_lfsr <= {bp_lfsr[30:0], bp_lfsr[31] ^ bp_lfsr[21] ^ bp_lfsr[1] ^ bp_lfsr[0]};
    if (bp_en) out_ready <= bp_lfsr[3] | bp_lfsr[7];
  end

  // Monitor: compares each transferred beat, checks holding while stalled.
  logic          was_stall = 1'b0;
  logic [AW-1:0] held_addr;
  logic [2:0]    held_mode;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (was_stall) begin
        check("R9", "hold addr", 64'(out_addr), 64'(held_addr));
        check("R9", "hold mode", 64'(out_mode), 64'(held_mode));
      end
      was_stall = out_valid && !out_ready;
      held_addr = out_addr;
      held_mode = out_mode;
      if (was_stall) check("R9", "in_ready in stall", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check("R8", "unexpected beat", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.req, "addr", 64'(out_addr), 64'(e.addr));
          check(e.req, "tiling", 64'(out_tiling), 64'(e.til));
          check(e.req, "mode", 64'(out_mode), 64'(e.rep));
          check(e.req, "phys", 64'(out_phys_mode), 64'(e.phys));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check("R1", "in_ready after reset", 64'(in_ready), 64'd1);
    // R1: registers reset to none, so an X beat passes unchanged.
    send(32'h0002_0E40, 2'd1);
    // R8: one-cycle latency.
    @(negedge clk); #1;
    check("R8", "out_valid one cycle later", 64'(out_valid), 64'd1);

    // R2 / R11 linear codes.
    send(32'hFFFF_FFFF, 2'd0);
    send(32'h0002_0640, 2'd3);

    // R4 / R3 / R7 / R6: every mode under X and Y.
    for (int m = 0; m < 8; m++) begin
      write_mode(1'b0, 3'(m));
      write_mode(1'b1, 3'(7 - m));
      send(32'h0000_0200, 2'd1);
      send(32'h0002_0C00, 2'd1);
      send(32'h0000_0E40, 2'd2);
      send(32'h0002_0A40, 2'd2);
      for (int k = 0; k < 4; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        send(lfsr, 2'(k));
      end
    end

    // R10: write during a stall must not change the held beat.
    write_mode(1'b0, 3'd1);
    @(negedge clk); out_ready = 1'b0;
    send(32'h0000_0200, 2'd1);
    write_mode(1'b0, 3'd0);
    @(negedge clk); #1;
    check("R10", "held addr keeps old mode", 64'(out_addr), 64'h0000_0240);
    check("R10", "held phys keeps old mode", 64'(out_phys_mode), 64'd1);
    @(negedge clk); out_ready = 1'b1;
    send(32'h0000_0200, 2'd1);

    // Random backpressure run.
    bp_en = 1'b1;
    for (int n = 0; n < 120; n++) begin
      if (n % 15 == 0) write_mode(n[4], 3'(n / 15));
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr, lfsr[9:8]);
    end
    bp_en = 1'b0;
    @(negedge clk); out_ready = 1'b1;
    repeat (5) @(negedge clk);
    check("R8", "scoreboard drained", 64'(sb.size()), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule